// File: doc/BRIEF.md
# Plane Register Double Buffer with Write-Triggered Arming

This block holds the configuration of one display plane as two copies of a twelve-entry register set. The CPU side writes a pending copy. The scanout side sees an active copy. The active copy changes only at a vertical-blank cycle, and only after the update has been armed. All twelve entries then move into the active copy in that one cycle. A partly written configuration is never seen by scanout.

No separate commit bit exists. Arming comes from the register that is written. A surface-address write always arms the update. The three offset registers arm it themselves. A control write arms it only while the plane is switched off in the active copy. The other registers wait for one of those writes. An arming write arms the whole pending set, so earlier unarmed writes go active with it. The `armed` output shows an update that is armed but has not yet been transferred.

Writes use a valid/ready port. `wr_ready` is low in every cycle where `vblank` is high. A write offered in such a cycle is held off, and the source must keep `wr_valid`, `wr_addr` and `wr_data` until a cycle with ready high. Because of this, a transfer never meets a write in the same cycle. The read port is combinational and returns the pending value. The whole active set is presented flat on `act_regs`, and the plane's position and size are also given decoded.

Top module: `plane_dbuf_regs`

## Requirements
- R1: After reset, every pending and active entry is zero, `armed` is low and `plane_on` is low.
- R2: The register addresses are: 0 stride, 1 position, 2 size, 3 key value, 4 key mask, 5 key max, 6 tiled offset, 7 linear offset, 8 combined offset, 9 scale, 10 control, 11 surface. A write to 0, 1, 2, 3, 4, 5 or 9 changes only the pending entry, which `rd_data` returns for that `rd_addr`. Such a write neither arms the update nor changes `act_regs`.
- R3: An accepted write to address 11 sets `armed`. In the next cycle with `vblank` high and `armed` set, all twelve pending entries are copied into the active set, with entry i at `act_regs[32*i +: 32]`, and `armed` clears. `armed` stays set until that cycle.
- R4: An accepted write to address 10 sets `armed` when bit 31 of the active control entry (`plane_on`) is 0. When that bit is 1, the write leaves `armed` as it was.
- R5: An accepted write to address 6, 7 or 8 sets `armed`.
- R6: A cycle with `vblank` high and `armed` low leaves every active entry unchanged.
- R7: `wr_ready` is the inverse of `vblank`. A write offered while `vblank` is high changes nothing.
- R8: A write to address 12 to 15 changes no entry and does not arm the update. `rd_data` is zero for those read addresses.
- R9: `act_pos_y` and `act_pos_x` are bits 31:16 and 15:0 of the active position entry. `act_height` and `act_width` are one more than bits 31:16 and 15:0 of the active size entry, 17 bits wide.
- R10: Writing zero to control while the plane is on, then writing surface, switches the plane off and loads the new surface in the same transfer. Before that transfer, the old control and surface stay active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Write offered |
| wr_ready | output | 1 | Write accepted this cycle (low during vertical blank) |
| wr_addr | input | 4 | Register address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Register address of the read |
| rd_data | output | 32 | Pending value at `rd_addr` |
| vblank | input | 1 | Vertical-blank transfer opportunity |
| armed | output | 1 | Update armed and not yet transferred |
| act_regs | output | 384 | Active set, entry i at bits 32*i+31:32*i |
| act_pos_x | output | 16 | Active horizontal position |
| act_pos_y | output | 16 | Active vertical position |
| act_width | output | 17 | Active width in pixels |
| act_height | output | 17 | Active height in lines |
| plane_on | output | 1 | Active control bit 31 |

## Verification
The assertions assume that reset is low at time zero. They also assume that every input is driven to a known level on each rising edge. They place no limit on how `vblank` is spaced, or on the addresses and data offered. The stimulus keeps to this by changing inputs only on the falling edge. Random cycles raise `vblank` about one time in eight and offer writes to all sixteen addresses, including 12 to 15. The random control data sets bit 31 either way, so both branches of the control arming rule are exercised. Directed sequences add the disable order, a write offered during vertical blank, and a blank with nothing armed.

// File: rtl/plane_regs_pkg.sv
package plane_regs_pkg;

  localparam int REG_DW = 32;
  localparam int NREG   = 12;
  localparam int AW     = 4;
  localparam int EN_BIT = 31;
  localparam int HALF   = REG_DW / 2;

  typedef enum logic [AW-1:0] {
    RA_STRIDE  = 4'd0,
    RA_POS     = 4'd1,
    RA_SIZE    = 4'd2,
    RA_KEYVAL  = 4'd3,
    RA_KEYMSK  = 4'd4,
    RA_KEYMAX  = 4'd5,
    RA_TILEOFS = 4'd6,
    RA_LINOFS  = 4'd7,
    RA_OFS     = 4'd8,
    RA_SCALE   = 4'd9,
    RA_CTRL    = 4'd10,
    RA_SURF    = 4'd11
  } reg_addr_e;

  typedef enum logic [1:0] {
    ARM_NONE,
    ARM_ALWAYS,
    ARM_IF_OFF
  } arm_kind_e;

  function automatic logic addr_ok(input logic [AW-1:0] a);
    return int'(a) < NREG;
  endfunction

  function automatic arm_kind_e arm_kind(input logic [AW-1:0] a);
    arm_kind_e k;
    case (a)
      RA_SURF, RA_TILEOFS, RA_LINOFS, RA_OFS: k = ARM_ALWAYS;
      RA_CTRL:                                k = ARM_IF_OFF;
      default:                                k = ARM_NONE;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/plane_pend_bank.sv
module plane_pend_bank #(
  parameter int N  = 12,
  parameter int DW = 32,
  parameter int AW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [DW-1:0]   wdata,
  input  logic [AW-1:0]   raddr,
  output logic [DW-1:0]   rdata,
  output logic [N*DW-1:0] pend_flat
);

  logic [DW-1:0] pend_q [N];

  for (genvar i = 0; i < N; i++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q[i] <= '0;
      end else if (we && (int'(waddr) == i)) begin
        pend_q[i] <= wdata;
      end
    end
    assign pend_flat[i*DW +: DW] = pend_q[i];
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < N; i++) begin
      if (int'(raddr) == i) rdata = pend_q[i];
    end
  end

endmodule

// File: rtl/plane_arm_ctrl.sv
module plane_arm_ctrl
  import plane_regs_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic          plane_on,
  input  logic          vblank,
  output logic          armed,
  output logic          xfer
);

  arm_kind_e kind;
  logic      arm_req;

  always_comb begin
    kind    = arm_kind(waddr);
    arm_req = 1'b0;
    if (we) begin
      case (kind)
        ARM_ALWAYS: arm_req = 1'b1;
        ARM_IF_OFF: arm_req = !plane_on;
        default:    arm_req = 1'b0;
      endcase
    end
  end

  assign xfer = vblank && armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
    end else if (xfer) begin
      armed <= 1'b0;
    end else if (arm_req) begin
      armed <= 1'b1;
    end
  end

endmodule

// File: rtl/plane_act_bank.sv
module plane_act_bank #(
  parameter int N  = 12,
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            xfer,
  input  logic [N*DW-1:0] pend_flat,
  output logic [N*DW-1:0] act_flat
);

  for (genvar i = 0; i < N; i++) begin : g_ent
    logic [DW-1:0] act_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        act_q <= '0;
      end else if (xfer) begin
        act_q <= pend_flat[i*DW +: DW];
      end
    end
    assign act_flat[i*DW +: DW] = act_q;
  end

endmodule

// File: rtl/plane_geom_decode.sv
module plane_geom_decode #(
  parameter int DW = 32,
  localparam int HW = DW / 2
) (
  input  logic [DW-1:0] pos_word,
  input  logic [DW-1:0] size_word,
  output logic [HW-1:0] pos_x,
  output logic [HW-1:0] pos_y,
  output logic [HW:0]   width,
  output logic [HW:0]   height
);

  assign pos_x  = pos_word[HW-1:0];
  assign pos_y  = pos_word[DW-1:HW];
  assign width  = {1'b0, size_word[HW-1:0]} + {{HW{1'b0}}, 1'b1};
  assign height = {1'b0, size_word[DW-1:HW]} + {{HW{1'b0}}, 1'b1};

endmodule

// File: rtl/plane_dbuf_regs.sv
module plane_dbuf_regs
  import plane_regs_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_valid,
  output logic                   wr_ready,
  input  logic [AW-1:0]          wr_addr,
  input  logic [REG_DW-1:0]      wr_data,
  input  logic [AW-1:0]          rd_addr,
  output logic [REG_DW-1:0]      rd_data,
  input  logic                   vblank,
  output logic                   armed,
  output logic [NREG*REG_DW-1:0] act_regs,
  output logic [HALF-1:0]        act_pos_x,
  output logic [HALF-1:0]        act_pos_y,
  output logic [HALF:0]          act_width,
  output logic [HALF:0]          act_height,
  output logic                   plane_on
);

  logic                   we;
  logic                   xfer;
  logic [NREG*REG_DW-1:0] pend_flat;

  assign wr_ready = !vblank;
  assign we       = wr_valid && wr_ready && addr_ok(wr_addr);
  assign plane_on = act_regs[int'(RA_CTRL)*REG_DW + EN_BIT];

  plane_pend_bank #(.N(NREG), .DW(REG_DW), .AW(AW)) i_pend (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (we),
    .waddr     (wr_addr),
    .wdata     (wr_data),
    .raddr     (rd_addr),
    .rdata     (rd_data),
    .pend_flat (pend_flat)
  );

  plane_arm_ctrl i_arm (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (we),
    .waddr    (wr_addr),
    .plane_on (plane_on),
    .vblank   (vblank),
    .armed    (armed),
    .xfer     (xfer)
  );

  plane_act_bank #(.N(NREG), .DW(REG_DW)) i_act (
    .clk       (clk),
    .rst_n     (rst_n),
    .xfer      (xfer),
    .pend_flat (pend_flat),
    .act_flat  (act_regs)
  );

  plane_geom_decode #(.DW(REG_DW)) i_geom (
    .pos_word  (act_regs[int'(RA_POS)*REG_DW +: REG_DW]),
    .size_word (act_regs[int'(RA_SIZE)*REG_DW +: REG_DW]),
    .pos_x     (act_pos_x),
    .pos_y     (act_pos_y),
    .width     (act_width),
    .height    (act_height)
  );

endmodule

// File: rtl/plane_dbuf_regs_chk.sv
module plane_dbuf_regs_chk
  import plane_regs_pkg::*;
(
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wr_valid,
  input logic                   wr_ready,
  input logic [AW-1:0]          wr_addr,
  input logic                   vblank,
  input logic                   armed,
  input logic [NREG*REG_DW-1:0] act_regs,
  input logic                   plane_on
);

  logic acc;
  assign acc = wr_valid && wr_ready;

  AST_READY_LOW_IN_VBLANK: assert property (@(posedge clk) disable iff (!rst_n)
    vblank |-> !wr_ready); // R7

  AST_SURF_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && wr_addr == 4'd11) |=> armed); // R3

  AST_KEEP_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !vblank) |=> armed); // R3

  AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && vblank) |=> !armed); // R3

  AST_CTRL_SELF_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && wr_addr == 4'd10 && !plane_on) |=> armed); // R4

  AST_CTRL_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && wr_addr == 4'd10 && plane_on && !armed) |=> !armed); // R4

  AST_OFFSET_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (wr_addr == 4'd6 || wr_addr == 4'd7 || wr_addr == 4'd8)) |=> armed); // R5

  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(vblank && armed) |=> $stable(act_regs)); // R6

  AST_BAD_ADDR_NO_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && wr_addr >= 4'd12 && !armed) |=> !armed); // R8

endmodule

bind plane_dbuf_regs plane_dbuf_regs_chk i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_valid (wr_valid),
  .wr_ready (wr_ready),
  .wr_addr  (wr_addr),
  .vblank   (vblank),
  .armed    (armed),
  .act_regs (act_regs),
  .plane_on (plane_on)
);

// File: tb/test_plane_dbuf_regs.sv
`timescale 1ns/1ps
module test_plane_dbuf_regs;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_valid = 1'b0;
  logic         wr_ready;
  logic [3:0]   wr_addr = '0;
  logic [31:0]  wr_data = '0;
  logic [3:0]   rd_addr = '0;
  logic [31:0]  rd_data;
  logic         vblank = 1'b0;
  logic         armed;
  logic [383:0] act_regs;
  logic [15:0]  act_pos_x, act_pos_y;
  logic [16:0]  act_width, act_height;
  logic         plane_on;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [31:0] m_pend [12];
  logic [31:0] m_act  [12];
  logic        m_armed;

  always #2 clk = ~clk;

  plane_dbuf_regs i_plane_dbuf_regs (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .vblank(vblank), .armed(armed), .act_regs(act_regs),
    .act_pos_x(act_pos_x), .act_pos_y(act_pos_y),
    .act_width(act_width), .act_height(act_height), .plane_on(plane_on)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic bit arms(input logic [3:0] a);
    return (a == 4'd11) || (a == 4'd6) || (a == 4'd7) || (a == 4'd8) ||
           (a == 4'd10 && !m_act[10][31]);
  endfunction

  task automatic compare(input string tag);
    logic [31:0] exp_rd;
    bit          act_ok = 1;
    int          bad = 0;
    exp_rd = (rd_addr < 4'd12) ? m_pend[rd_addr] : 32'd0;
    chk(armed === m_armed, tag, "armed", 64'(armed), 64'(m_armed));
    for (int i = 0; i < 12; i++) begin
      if (act_regs[32*i +: 32] !== m_act[i] && act_ok) begin
        act_ok = 0;
        bad = i;
      end
    end
    chk(act_ok, tag, $sformatf("active entry %0d", bad),
        64'(act_regs[32*bad +: 32]), 64'(m_act[bad]));
    chk(rd_data === exp_rd, tag, "rd_data", 64'(rd_data), 64'(exp_rd));
    chk({act_pos_y, act_pos_x} === m_act[1], "R9", "position",
        64'({act_pos_y, act_pos_x}), 64'(m_act[1]));
    chk({act_height, act_width} === {17'(m_act[2][31:16]) + 17'd1, 17'(m_act[2][15:0]) + 17'd1},
        "R9", "size", 64'({act_height, act_width}),
        64'({17'(m_act[2][31:16]) + 17'd1, 17'(m_act[2][15:0]) + 17'd1}));
    chk(plane_on === m_act[10][31], tag, "plane_on", 64'(plane_on), 64'(m_act[10][31]));
  endtask

  task automatic step(input logic v, input logic [3:0] a, input logic [31:0] d,
                      input logic vb, input logic [3:0] ra, input string tag);
    wr_valid = v; wr_addr = a; wr_data = d; vblank = vb; rd_addr = ra;
    #1;
    chk(wr_ready === !vb, "R7", "wr_ready", 64'(wr_ready), 64'(!vb));
    @(posedge clk);
    if (vb) begin
      if (m_armed) begin
        for (int i = 0; i < 12; i++) m_act[i] = m_pend[i];
        m_armed = 1'b0;
      end
    end else if (v && a < 4'd12) begin
      if (arms(a)) m_armed = 1'b1;
      m_pend[a] = d;
    end
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20181108));
    for (int i = 0; i < 12; i++) begin
      m_pend[i] = '0;
      m_act[i]  = '0;
    end
    m_armed = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");

    // R2: non-arming registers stay pending
    step(1, 4'd0, 32'h0000_1000, 0, 4'd0, "R2");
    step(1, 4'd1, 32'h0020_0010, 0, 4'd1, "R2");
    step(1, 4'd2, 32'h01DF_027F, 0, 4'd2, "R2");
    step(1, 4'd4, 32'h00FF_00FF, 0, 4'd4, "R2");
    step(1, 4'd9, 32'h8000_0000, 0, 4'd9, "R2");
    // R6: blank with nothing armed
    step(0, 4'd0, 32'd0, 1, 4'd0, "R6");
    // R8: out-of-range address
    step(1, 4'd13, 32'hDEAD_BEEF, 0, 4'd13, "R8");
    step(0, 4'd0, 32'd0, 1, 4'd1, "R8");
    // R7: write offered during blank is held off
    step(1, 4'd0, 32'h5555_5555, 1, 4'd0, "R7");
    // R4: control self-arms while plane off; R3 transfer with earlier writes
    step(1, 4'd10, 32'h8000_0001, 0, 4'd10, "R4");
    step(0, 4'd0, 32'd0, 0, 4'd10, "R3");
    step(0, 4'd0, 32'd0, 1, 4'd2, "R3");
    // R5: offset self-arms
    step(1, 4'd7, 32'h0000_4000, 0, 4'd7, "R5");
    step(0, 4'd0, 32'd0, 1, 4'd7, "R5");
    // R3: surface arms
    step(1, 4'd11, 32'h0010_0000, 0, 4'd11, "R3");
    step(0, 4'd0, 32'd0, 1, 4'd11, "R3");
    // R10: disable sequence
    step(1, 4'd10, 32'h0000_0000, 0, 4'd10, "R10");
    step(0, 4'd0, 32'd0, 1, 4'd10, "R10");
    step(1, 4'd11, 32'h0020_0000, 0, 4'd11, "R10");
    step(0, 4'd0, 32'd0, 1, 4'd11, "R10");
    // R4: control while plane on does not arm
    step(1, 4'd10, 32'h8000_0000, 0, 4'd10, "R4");
    step(1, 4'd11, 32'h0030_0000, 0, 4'd11, "R4");
    step(0, 4'd0, 32'd0, 1, 4'd10, "R4");
    step(1, 4'd10, 32'h0000_0002, 0, 4'd10, "R4");
    step(0, 4'd0, 32'd0, 1, 4'd10, "R4");

    // random mix: R2 R3 R4 R5 R6 R7 R8
    for (int n = 0; n < 4000; n++) begin
      step(1'($urandom % 2), 4'($urandom % 16), $urandom,
           ($urandom % 8) == 0, 4'($urandom % 16), "R2/R3/R4/R5/R6/R7/R8");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule